// File: doc/BRIEF.md
# Owned-State Probe Coherence Controller

This block keeps the coherence state of a small set of cache lines for one cache in a five-state scheme (Modified, Owned, Exclusive, Shared, Invalid). Each cycle it can take one processor access and one incoming probe from another bus master. For a processor access it reports hit or miss and whether the other caches have to be invalidated. For a probe it reports whether the line is held here and whether this cache must supply the data, and it updates the line state. The data array, the bus wires and replacement belong to the surrounding cache.

The Owned state lets a cache pass dirty data to readers without writing memory back first. The single cache in Modified or Owned answers reads, and the other copies sit in Shared. A probe from a device that will not cache the data, such as an I/O master, can still draw the data out but leaves every line state as it was. A processor write that misses runs in two steps. The line is first filled into Exclusive, as for a read miss. In the following cycle the write completes and the line becomes Modified. The controller is busy during that second cycle.

The surrounding bus logic probes the other caches first. It then presents the processor access with a flag telling whether any of those caches still holds the line. It keeps a processor access and a probe in the same cycle on different lines, and it does not probe the line whose write is completing.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid, and cpu_hit, cpu_miss, cpu_bcast, busy, prb_present and prb_supply are all low. The state codes on look_state are Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R2: A processor read of a line that is not Invalid raises cpu_hit with cpu_miss low and leaves the state unchanged.
- R3: A processor read of an Invalid line raises cpu_miss. The line becomes Shared at the next edge if peer_shared is high, and Exclusive if it is low.
- R4: A processor write hit raises cpu_hit and leaves the line Modified. A line already in Modified or Exclusive changes with cpu_bcast low. A line in Shared or Owned changes with cpu_bcast high, because other copies must be invalidated.
- R5: A processor write to an Invalid line raises cpu_miss and cpu_bcast. After the first edge the line is Exclusive and busy is high. After the second edge the line is Modified and busy is low again.
- R6: A caching read probe (prb_wr=0, prb_nocache=0) turns Modified into Owned and supplies the data. An Owned line supplies and stays Owned. An Exclusive line becomes Shared without supplying. Shared and Invalid lines are unchanged and do not supply.
- R7: A non-caching read probe (prb_wr=0, prb_nocache=1) leaves the line state unchanged in every state, and supplies the data exactly when the line is Modified or Owned.
- R8: A write probe (prb_wr=1) leaves the line Invalid from any state. It supplies the data exactly when the line was Modified or Owned, and prb_nocache has no effect on it.
- R9: During a probe, prb_present is high exactly when the probed line is not Invalid.
- R10: When several controllers are driven through the probe-then-access sequence, each line has at most one cache in Modified, Owned or Exclusive. A Modified or Exclusive copy is the only copy. Every read returns the most recently written value, taken from the supplying cache if one exists and from memory otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access valid |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_idx | input | IDX_W | Line addressed by the processor |
| peer_shared | input | 1 | Another cache still holds the line (read miss fill) |
| cpu_hit | output | 1 | Processor access hits |
| cpu_miss | output | 1 | Processor access misses |
| cpu_bcast | output | 1 | Other copies must be invalidated |
| busy | output | 1 | Write miss completing; processor accesses are not taken |
| prb_req | input | 1 | Probe valid |
| prb_wr | input | 1 | Probe is a write (invalidating) probe |
| prb_nocache | input | 1 | Read probe from a master that will not cache the data |
| prb_idx | input | IDX_W | Line addressed by the probe |
| prb_present | output | 1 | Probed line held here |
| prb_supply | output | 1 | This cache must supply the data |
| look_idx | input | IDX_W | Line whose state is shown on look_state |
| look_state | output | 3 | State code of line look_idx |

## Verification
Three controllers share a bench-side bus and memory model, and a behavioural reference compares every line's state on each clock. A lone read against a read with a sharer present tells the Exclusive fill apart from the Shared fill. Writes started from each of the five states separate the silent upgrade, the broadcast upgrade and the two-step miss. Caching, non-caching and write probes on Modified, Owned, Exclusive, Shared and Invalid lines show whether ownership moves or stays. A long random mix of reads, writes and non-caching reads over three caches checks that every read sees the latest write and that a line never has two owners.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

   typedef enum logic [2:0] {
      LS_I = 3'd0,
      LS_S = 3'd1,
      LS_E = 3'd2,
      LS_O = 3'd3,
      LS_M = 3'd4
   } line_st_t;

   // newest data lives here and memory may be stale
   function automatic logic st_dirty(line_st_t s);
      return (s == LS_M) || (s == LS_O);
   endfunction

   function automatic logic st_valid(line_st_t s);
      return s != LS_I;
   endfunction

endpackage

// File: rtl/moesi_cpu_side.sv
module moesi_cpu_side
   import moesi_pkg::*;
(
   input  logic     req,
   input  logic     wr,
   input  logic     peer_shared,
   input  line_st_t cur,
   output logic     hit,
   output logic     miss,
   output logic     bcast,
   output logic     upd,
   output logic     wmiss_start,
   output line_st_t nxt
);

   always_comb begin
      hit         = 1'b0;
      miss        = 1'b0;
      bcast       = 1'b0;
      upd         = 1'b0;
      wmiss_start = 1'b0;
      nxt         = cur;
      if (req) begin
         if (!st_valid(cur)) begin
            miss = 1'b1;
            upd  = 1'b1;
            if (wr) begin
               // first step of a write miss: fill as exclusive
               bcast       = 1'b1;
               wmiss_start = 1'b1;
               nxt         = LS_E;
            end else begin
               nxt = peer_shared ? LS_S : LS_E;
            end
         end else begin
            hit = 1'b1;
            if (wr) begin
               nxt   = LS_M;
               upd   = (cur != LS_M);
               bcast = (cur == LS_S) || (cur == LS_O);
            end
         end
      end
   end

endmodule

// File: rtl/moesi_probe_side.sv
module moesi_probe_side
   import moesi_pkg::*;
(
   input  logic     req,
   input  logic     wr,
   input  logic     nocache,
   input  line_st_t cur,
   output logic     present,
   output logic     supply,
   output logic     upd,
   output line_st_t nxt
);

   always_comb begin
      present = 1'b0;
      supply  = 1'b0;
      upd     = 1'b0;
      nxt     = cur;
      if (req) begin
         present = st_valid(cur);
         supply  = st_dirty(cur);
         if (wr) begin
            nxt = LS_I;
            upd = st_valid(cur);
         end else if (!nocache) begin
            unique case (cur)
               LS_M:    begin nxt = LS_O; upd = 1'b1; end
               LS_E:    begin nxt = LS_S; upd = 1'b1; end
               default: nxt = cur;
            endcase
         end
      end
   end

endmodule

// File: rtl/moesi_state_table.sv
module moesi_state_table
   import moesi_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin_we,
   input  logic [IDX_W-1:0] fin_idx,
   input  logic             prb_we,
   input  logic [IDX_W-1:0] prb_widx,
   input  line_st_t         prb_wst,
   input  logic             cpu_we,
   input  logic [IDX_W-1:0] cpu_widx,
   input  line_st_t         cpu_wst,
   output line_st_t         st_o [NUM_LINES]
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      line_st_t st_q;
      logic     fin_hit, prb_hit, cpu_hit;

      assign fin_hit = fin_we && (fin_idx  == IDX_W'(i));
      assign prb_hit = prb_we && (prb_widx == IDX_W'(i));
      assign cpu_hit = cpu_we && (cpu_widx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       st_q <= LS_I;
         else if (fin_hit) st_q <= LS_M;
         else if (prb_hit) st_q <= prb_wst;
         else if (cpu_hit) st_q <= cpu_wst;
      end

      assign st_o[i] = st_q;
   end

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
   import moesi_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_wr,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic             peer_shared,
   output logic             cpu_hit,
   output logic             cpu_miss,
   output logic             cpu_bcast,
   output logic             busy,
   input  logic             prb_req,
   input  logic             prb_wr,
   input  logic             prb_nocache,
   input  logic [IDX_W-1:0] prb_idx,
   output logic             prb_present,
   output logic             prb_supply,
   input  logic [IDX_W-1:0] look_idx,
   output logic [2:0]       look_state
);

   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("moesi_ctrl: NUM_LINES must be within 2..256");
   end
   if ((1 << IDX_W) != NUM_LINES) begin : g_bad_pow2
      $error("moesi_ctrl: NUM_LINES must be a power of two");
   end

   line_st_t         st [NUM_LINES];
   line_st_t         cpu_cur, prb_cur, cpu_nxt, prb_nxt;
   logic             cpu_req_g, cpu_upd, prb_upd, wmiss_start;
   logic             pend_q;
   logic [IDX_W-1:0] pend_idx_q;

   assign cpu_req_g = cpu_req && !pend_q;
   assign cpu_cur   = st[cpu_idx];
   assign prb_cur   = st[prb_idx];

   moesi_cpu_side u_cpu (
      .req         (cpu_req_g),
      .wr          (cpu_wr),
      .peer_shared (peer_shared),
      .cur         (cpu_cur),
      .hit         (cpu_hit),
      .miss        (cpu_miss),
      .bcast       (cpu_bcast),
      .upd         (cpu_upd),
      .wmiss_start (wmiss_start),
      .nxt         (cpu_nxt)
   );

   moesi_probe_side u_prb (
      .req     (prb_req),
      .wr      (prb_wr),
      .nocache (prb_nocache),
      .cur     (prb_cur),
      .present (prb_present),
      .supply  (prb_supply),
      .upd     (prb_upd),
      .nxt     (prb_nxt)
   );

   // second step of a write miss
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
      end else begin
         pend_q <= wmiss_start;
         if (wmiss_start) pend_idx_q <= cpu_idx;
      end
   end

   moesi_state_table #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fin_we   (pend_q),
      .fin_idx  (pend_idx_q),
      .prb_we   (prb_upd),
      .prb_widx (prb_idx),
      .prb_wst  (prb_nxt),
      .cpu_we   (cpu_upd),
      .cpu_widx (cpu_idx),
      .cpu_wst  (cpu_nxt),
      .st_o     (st)
   );

   assign busy       = pend_q;
   assign look_state = st[look_idx];

   // R3
   rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_g && !cpu_wr && cpu_miss) |=>
         st[$past(cpu_idx)] == ($past(peer_shared) ? LS_S : LS_E));

   // R4
   wr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_g && cpu_wr && cpu_hit) |=> st[$past(cpu_idx)] == LS_M);

   // R5
   wmiss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_g && cpu_wr && cpu_miss) |=> (busy && st[pend_idx_q] == LS_E));

   // R5
   busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy && st[$past(pend_idx_q)] == LS_M));

   // R6
   excl_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_req && !prb_wr && !prb_nocache && prb_cur == LS_E) |=>
         st[$past(prb_idx)] == LS_S);

   // R7
   nc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_req && !prb_wr && prb_nocache) |=> st[$past(prb_idx)] == $past(prb_cur));

   // R8
   wprb_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_req && prb_wr) |=> st[$past(prb_idx)] == LS_I);

   // R9
   present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_req && prb_cur == LS_I) |-> !prb_present && !prb_supply);

   // usage rule: one access per line per cycle
   same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_g && prb_req) |-> cpu_idx != prb_idx);

   // usage rule: completing line is not probed
   pend_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && prb_req) |-> prb_idx != pend_idx_q);

endmodule

// File: tb/moesi_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_ctrl_tb;

   localparam int NC = 3;
   localparam int NL = 8;
   localparam int IW = 3;
   localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_O = 3, ST_M = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          cpu_req [NC], cpu_wr [NC], peer_sh [NC];
   logic          prb_req [NC], prb_wr [NC], prb_nc [NC];
   logic [IW-1:0] cpu_idx [NC], prb_idx [NC];
   logic          hit [NC], miss [NC], bc [NC], bsy [NC], pres [NC], sup [NC];
   logic [2:0]    lk [NC];
   logic [IW-1:0] look_idx = '0;

   for (genvar g = 0; g < NC; g++) begin : g_c
      moesi_ctrl #(.NUM_LINES(NL)) u_dut (
         .clk         (clk),
         .rst_n       (rst_n),
         .cpu_req     (cpu_req[g]),
         .cpu_wr      (cpu_wr[g]),
         .cpu_idx     (cpu_idx[g]),
         .peer_shared (peer_sh[g]),
         .cpu_hit     (hit[g]),
         .cpu_miss    (miss[g]),
         .cpu_bcast   (bc[g]),
         .busy        (bsy[g]),
         .prb_req     (prb_req[g]),
         .prb_wr      (prb_wr[g]),
         .prb_nocache (prb_nc[g]),
         .prb_idx     (prb_idx[g]),
         .prb_present (pres[g]),
         .prb_supply  (sup[g]),
         .look_idx    (look_idx),
         .look_state  (lk[g])
      );
   end

   int mst [NC][NL];
   int cdata [NC][NL];
   int mem [NL];
   int latest [NL];
   int wcount = 0;
   int total = 0;
   int bad = 0;
   bit run = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit isd(int s);
      return (s == ST_M) || (s == ST_O);
   endfunction

   task automatic clr();
      for (int c = 0; c < NC; c++) begin
         cpu_req[c] = 0; cpu_wr[c] = 0; peer_sh[c] = 0; cpu_idx[c] = '0;
         prb_req[c] = 0; prb_wr[c] = 0; prb_nc[c] = 0;  prb_idx[c] = '0;
      end
   endtask

   // sweep the look port and compare every cache's state each cycle
   always @(posedge clk) begin
      #2 look_idx <= look_idx + 1'b1;
   end

   always @(negedge clk) begin
      if (run) begin
         for (int c = 0; c < NC; c++) chk("R10 state table", lk[c], mst[c][look_idx]);
      end
   end

   task automatic peek(input int k, input int l, input int exp, input string req);
      @(negedge clk);
      while (look_idx != IW'(l)) @(negedge clk);
      chk(req, lk[k], exp);
   endtask

   task automatic owner_chk(input int l);
      int own, cnt;
      bit sole;
      own = 0; cnt = 0; sole = 0;
      for (int c = 0; c < NC; c++) begin
         if (mst[c][l] == ST_M || mst[c][l] == ST_O || mst[c][l] == ST_E) own++;
         if (mst[c][l] == ST_M || mst[c][l] == ST_E) sole = 1;
         if (mst[c][l] != ST_I) cnt++;
      end
      chk("R10 single owner", (own <= 1) ? 1 : 0, 1);
      if (sole) chk("R10 sole copy", cnt, 1);
   endtask

   task automatic rd(input int k, input int l);
      int val, s;
      bit anyp;
      val = mem[l]; anyp = 0;
      if (mst[k][l] != ST_I) begin
         @(negedge clk);
         cpu_req[k] = 1; cpu_wr[k] = 0; cpu_idx[k] = IW'(l);
         #1;
         chk("R2 read hit", hit[k], 1);
         chk("R2 read hit miss flag", miss[k], 0);
         val = cdata[k][l];
         @(posedge clk); #1; clr();
      end else begin
         @(negedge clk);
         for (int j = 0; j < NC; j++) if (j != k) begin
            prb_req[j] = 1; prb_wr[j] = 0; prb_nc[j] = 0; prb_idx[j] = IW'(l);
         end
         #1;
         for (int j = 0; j < NC; j++) if (j != k) begin
            s = mst[j][l];
            chk("R6 read probe supply", sup[j], isd(s));
            chk("R9 probe present", pres[j], (s != ST_I) ? 1 : 0);
            if (s != ST_I) anyp = 1;
            if (isd(s)) val = cdata[j][l];
         end
         @(posedge clk); #1; clr();
         for (int j = 0; j < NC; j++) if (j != k) begin
            if (mst[j][l] == ST_M) mst[j][l] = ST_O;
            else if (mst[j][l] == ST_E) mst[j][l] = ST_S;
         end
         @(negedge clk);
         cpu_req[k] = 1; cpu_wr[k] = 0; cpu_idx[k] = IW'(l); peer_sh[k] = anyp;
         #1;
         chk("R3 read miss", miss[k], 1);
         chk("R3 read miss hit flag", hit[k], 0);
         @(posedge clk); #1; clr();
         mst[k][l] = anyp ? ST_S : ST_E;
         cdata[k][l] = val;
      end
      chk("R10 fresh read", val, latest[l]);
      owner_chk(l);
   endtask

   task automatic wr(input int k, input int l, input bit ncflag = 0);
      int s, nv;
      s = mst[k][l];
      wcount++; nv = 1000 + wcount;
      if (s == ST_M || s == ST_E) begin
         @(negedge clk);
         cpu_req[k] = 1; cpu_wr[k] = 1; cpu_idx[k] = IW'(l);
         #1;
         chk("R4 silent write hit", hit[k], 1);
         chk("R4 silent write bcast", bc[k], 0);
         @(posedge clk); #1; clr();
         mst[k][l] = ST_M;
      end else begin
         @(negedge clk);
         for (int j = 0; j < NC; j++) if (j != k) begin
            prb_req[j] = 1; prb_wr[j] = 1; prb_nc[j] = ncflag; prb_idx[j] = IW'(l);
         end
         #1;
         for (int j = 0; j < NC; j++) if (j != k) begin
            chk("R8 write probe supply", sup[j], isd(mst[j][l]));
            chk("R9 probe present", pres[j], (mst[j][l] != ST_I) ? 1 : 0);
         end
         @(posedge clk); #1; clr();
         for (int j = 0; j < NC; j++) if (j != k) mst[j][l] = ST_I;
         @(negedge clk);
         cpu_req[k] = 1; cpu_wr[k] = 1; cpu_idx[k] = IW'(l);
         #1;
         if (s != ST_I) begin
            chk("R4 upgrade hit", hit[k], 1);
            chk("R4 upgrade bcast", bc[k], 1);
            @(posedge clk); #1; clr();
            mst[k][l] = ST_M;
         end else begin
            chk("R5 write miss", miss[k], 1);
            chk("R5 write miss bcast", bc[k], 1);
            @(posedge clk); #1; clr();
            mst[k][l] = ST_E;
            chk("R5 busy after first step", bsy[k], 1);
            @(posedge clk); #1;
            mst[k][l] = ST_M;
            chk("R5 busy cleared", bsy[k], 0);
         end
      end
      cdata[k][l] = nv;
      latest[l] = nv;
      owner_chk(l);
   endtask

   task automatic ncrd(input int l);
      int val;
      val = mem[l];
      @(negedge clk);
      for (int j = 0; j < NC; j++) begin
         prb_req[j] = 1; prb_wr[j] = 0; prb_nc[j] = 1; prb_idx[j] = IW'(l);
      end
      #1;
      for (int j = 0; j < NC; j++) begin
         chk("R7 noncaching supply", sup[j], isd(mst[j][l]));
         if (isd(mst[j][l])) val = cdata[j][l];
      end
      @(posedge clk); #1; clr();
      chk("R10 fresh noncaching read", val, latest[l]);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clr();
      for (int c = 0; c < NC; c++)
         for (int l = 0; l < NL; l++) begin
            mst[c][l] = ST_I; cdata[c][l] = 0;
         end
      for (int l = 0; l < NL; l++) begin
         mem[l] = 100 + l; latest[l] = 100 + l;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      run = 1'b1;
      for (int c = 0; c < NC; c++) begin
         chk("R1 reset hit", hit[c], 0);
         chk("R1 reset miss", miss[c], 0);
         chk("R1 reset bcast", bc[c], 0);
         chk("R1 reset busy", bsy[c], 0);
         chk("R1 reset present", pres[c], 0);
         chk("R1 reset supply", sup[c], 0);
      end
      for (int l = 0; l < NL; l++)
         for (int c = 0; c < NC; c++) peek(c, l, ST_I, "R1 reset state");

      rd(0, 1);                        peek(0, 1, ST_E, "R3 lone fill exclusive");
      rd(0, 1);                        peek(0, 1, ST_E, "R2 hit keeps state");
      rd(1, 1);                        peek(0, 1, ST_S, "R6 exclusive demoted");
                                       peek(1, 1, ST_S, "R3 shared fill");
      wr(1, 1);                        peek(0, 1, ST_I, "R8 invalidated");
                                       peek(1, 1, ST_M, "R4 shared upgraded");
      rd(2, 1);                        peek(1, 1, ST_O, "R6 modified to owned");
      rd(0, 1);                        peek(1, 1, ST_O, "R6 owned stays owned");
      ncrd(1);                         peek(1, 1, ST_O, "R7 owned unchanged");
                                       peek(0, 1, ST_S, "R7 shared unchanged");
      wr(2, 2);                        peek(2, 2, ST_M, "R5 write miss modified");
      ncrd(2);                         peek(2, 2, ST_M, "R7 modified unchanged");
      rd(0, 5);  ncrd(5);              peek(0, 5, ST_E, "R7 exclusive unchanged");
      wr(2, 2);                        peek(2, 2, ST_M, "R4 modified stays");
      rd(0, 2);                        peek(2, 2, ST_O, "R6 owner after read");
      wr(2, 2, 1'b1);                  peek(0, 2, ST_I, "R8 nocache flag ignored");
      wr(0, 5);                        peek(0, 5, ST_M, "R4 exclusive silent upgrade");
      rd(1, 3);  rd(2, 3);  wr(0, 3);  peek(1, 3, ST_I, "R8 shared invalidated");
      rd(0, 3);                        peek(0, 3, ST_M, "R2 hit after write miss");

      for (int n = 0; n < 400; n++) begin
         int k, l, op;
         k  = $urandom_range(0, NC - 1);
         l  = $urandom_range(0, NL - 1);
         op = $urandom_range(0, 4);
         if (op < 2)      rd(k, l);
         else if (op < 4) wr(k, l);
         else             ncrd(l);
      end

      repeat (NL) @(negedge clk);
      run = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule